// File: doc/BRIEF.md
# Frame Sync Detector with Flywheel

This block sits on the recovered channel-bit stream of an optical disc reader. It runs on the PLL bit clock and samples one channel bit per clock. It looks for the 24-bit frame synchronization pattern. A free-running phase counter, called the flywheel, predicts where the next pattern should appear. The counter emits a frame boundary every 588 bits. It does so whether or not a real pattern arrived, so a missing sync is replaced by an interpolated one and readout keeps its frame timing.

Matches that fall on the predicted slot confirm the timing. After enough confirmations the block declares lock. While locked, a pattern at any other position is treated as noise and never moves the counter. A run of empty predicted slots drops lock, and the block then hunts for a fresh pattern. A separate monitor output rises after each agreement between a detected pattern and the predicted slot, and stays high for one frame period.

Top module: `frame_sync_flywheel`

## Requirements
- R1: After reset, `frame_strobe`, `locked` and `sync_agree` are 0. No strobe appears while no pattern has ever been seen.
- R2: A pattern is recognized when the last 24 sampled bits equal 100000000001000000000010, with the earliest-received bit leftmost. The resulting strobe is visible in the clock cycle right after the edge that samples the final pattern bit.
- R3: While hunting (no timing), the first recognized pattern sets the frame timing and produces a strobe.
- R4: Once timing is set, a strobe occurs exactly FRAME_LEN (588) cycles after the previous timing point, whether or not a pattern is present there (interpolation).
- R5: `sync_agree` rises in the cycle after a pattern falls on a predicted slot and stays high for exactly FRAME_LEN cycles. Each further agreement restarts that window. An acquisition pattern does not raise it.
- R6: `locked` rises in the cycle after the LOCK_HITS-th (2nd) consecutive pattern found on a predicted slot since the last acquisition or re-timing.
- R7: While locked, a pattern at a position other than the predicted slot produces no strobe and does not move the frame timing.
- R8: While locked, LOSS_MISSES (8) consecutive predicted slots without a pattern clear `locked` in the cycle after the 8th empty slot. The 8th empty slot still strobes. No strobe follows until a new pattern re-times the counter.
- R9: While timed but not locked, a pattern off the predicted slot re-times the counter, strobes, and restarts the confirmation count from zero.
- R10: Each strobe lasts a single clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_bit | input | 1 | Serial channel bit, one per clock |
| frame_strobe | output | 1 | One-cycle frame boundary, real or interpolated |
| locked | output | 1 | Frame timing confirmed |
| sync_agree | output | 1 | High for one frame after a pattern meets a predicted slot |

## Verification
The bench aims at four corner cases:
- A single empty frame while locked. It must still strobe on the exact bit; a design without interpolation would go silent or drop lock at once.
- A spurious pattern mid-frame while locked. A design without protection would re-time and shift every later strobe.
- Exactly eight empty frames. Lock must survive seven and fall on the eighth; an off-by-one counter unlocks a frame early or late.
- An early pattern during confirmation. It must restart the lock count, or the block locks one frame too soon. The monitor window length is counted to the cycle, so a window that is one cycle short or long shows up.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  // Down-counting phase: wraps to len-1 after reaching zero.
  function automatic int next_phase(int cur, int len);
    return (cur == 0) ? len - 1 : cur - 1;
  endfunction

  // Saturating increment.
  function automatic int sat_inc(int v, int lim);
    return (v < lim) ? v + 1 : lim;
  endfunction
endpackage

// File: rtl/fsf_shift_match.sv
module fsf_shift_match #(
  parameter int SYNC_W = 24,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 24'b100000000001000000000010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic match
);
  logic [SYNC_W-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) win <= '0;
    else        win <= {win[SYNC_W-2:0], bit_in};
  end

  assign match = (win == SYNC_PAT);
endmodule

// File: rtl/fsf_phase_counter.sv
module fsf_phase_counter
  import fsf_pkg::*;
#(
  parameter int FRAME_LEN = 588,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retime,
  input  logic stop,
  output logic due
);
  logic [CW-1:0] phase;
  logic          timed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      timed <= 1'b0;
    end else if (retime) begin
      phase <= CW'(FRAME_LEN - 1);
      timed <= 1'b1;
    end else if (stop) begin
      timed <= 1'b0;
    end else if (timed) begin
      phase <= CW'(next_phase(int'(phase), FRAME_LEN));
    end
  end

  assign due = timed && (phase == '0);
endmodule

// File: rtl/fsf_lock_fsm.sv
module fsf_lock_fsm
  import fsf_pkg::*;
#(
  parameter int LOCK_HITS   = 2,
  parameter int LOSS_MISSES = 8,
  localparam int HW = $clog2(LOCK_HITS + 1),
  localparam int MW = $clog2(LOSS_MISSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic miss,
  input  logic retime,
  output logic locked,
  output logic loss
);
  logic [HW-1:0] hits;
  logic [MW-1:0] misses;

  assign loss = locked && miss && (int'(misses) == LOSS_MISSES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      hits   <= '0;
      misses <= '0;
    end else if (retime) begin
      hits <= '0;
    end else if (hit) begin
      misses <= '0;
      if (!locked) begin
        hits <= HW'(sat_inc(int'(hits), LOCK_HITS));
        if (sat_inc(int'(hits), LOCK_HITS) >= LOCK_HITS) locked <= 1'b1;
      end
    end else if (miss) begin
      if (loss) begin
        locked <= 1'b0;
        misses <= '0;
        hits   <= '0;
      end else if (locked) begin
        misses <= MW'(sat_inc(int'(misses), LOSS_MISSES));
      end else begin
        hits <= '0;
      end
    end
  end
endmodule

// File: rtl/fsf_agree_hold.sv
module fsf_agree_hold #(
  parameter int FRAME_LEN = 588,
  localparam int AW = $clog2(FRAME_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  logic [AW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)           left <= '0;
    else if (load)        left <= AW'(FRAME_LEN);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign active = (left != '0);
endmodule

// File: rtl/frame_sync_flywheel.sv
module frame_sync_flywheel #(
  parameter int FRAME_LEN   = 588,
  parameter int SYNC_W      = 24,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 24'b100000000001000000000010,
  parameter int LOCK_HITS   = 2,
  parameter int LOSS_MISSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_bit,
  output logic frame_strobe,
  output logic locked,
  output logic sync_agree
);
  logic sync_match;
  logic slot_due;
  logic slot_hit;
  logic slot_miss;
  logic retime_evt;
  logic loss_evt;

  fsf_shift_match #(.SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT)) u_match (
    .clk(clk), .rst_n(rst_n), .bit_in(chan_bit), .match(sync_match));

  fsf_phase_counter #(.FRAME_LEN(FRAME_LEN)) u_phase (
    .clk(clk), .rst_n(rst_n), .retime(retime_evt), .stop(loss_evt), .due(slot_due));

  assign slot_hit   = slot_due && sync_match;
  assign slot_miss  = slot_due && !sync_match;
  assign retime_evt = sync_match && !slot_due && !locked;

  fsf_lock_fsm #(.LOCK_HITS(LOCK_HITS), .LOSS_MISSES(LOSS_MISSES)) u_lock (
    .clk(clk), .rst_n(rst_n), .hit(slot_hit), .miss(slot_miss),
    .retime(retime_evt), .locked(locked), .loss(loss_evt));

  fsf_agree_hold #(.FRAME_LEN(FRAME_LEN)) u_agree (
    .clk(clk), .rst_n(rst_n), .load(slot_hit), .active(sync_agree));

  assign frame_strobe = slot_due || retime_evt;
endmodule

// File: rtl/fsf_checker.sv
module fsf_checker #(
  parameter int FRAME_LEN = 588,
  localparam int SW = $clog2(FRAME_LEN + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic frame_strobe,
  input logic locked,
  input logic sync_agree,
  input logic match_w,
  input logic expect_w
);
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)            since <= '0;
    else if (frame_strobe) since <= SW'(1);
    else if (int'(since) <= FRAME_LEN) since <= since + 1'b1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && frame_strobe) |=> !frame_strobe); // R10
  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && frame_strobe) |-> (int'(since) == FRAME_LEN)); // R4
  AST_AGREE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_agree) |-> $past(frame_strobe && match_w && expect_w)); // R5
  AST_LOCK_WITH_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> sync_agree); // R6
  AST_PROTECT_OFFSLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && match_w && !expect_w) |-> !frame_strobe); // R7
  AST_LOSS_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(expect_w && !match_w)); // R8
endmodule

bind frame_sync_flywheel fsf_checker #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .locked(locked),
  .sync_agree(sync_agree), .match_w(sync_match), .expect_w(slot_due));

// File: tb/frame_sync_flywheel_tb.sv
`timescale 1ns/1ps
module frame_sync_flywheel_tb;
  localparam int FL = 588;
  localparam logic [23:0] PAT = 24'b100000000001000000000010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_bit = 1'b0;
  logic frame_strobe, locked, sync_agree;

  int checks = 0;
  int errors = 0;
  int s_cnt, s_first, s_last, a_hi, l_end, l_rise;

  always #2 clk = ~clk;

  frame_sync_flywheel u_dut (
    .clk(clk), .rst_n(rst_n), .chan_bit(chan_bit),
    .frame_strobe(frame_strobe), .locked(locked), .sync_agree(sync_agree));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic b);
    chan_bit = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Sends one 588-bit frame; pattern at sync_at and/or extra_at (-1 = none).
  task automatic send_frame(input int sync_at, input int extra_at);
    logic fb [FL];
    int prev_l;
    for (int i = 0; i < FL; i++) fb[i] = (i % 3 == 0);
    for (int p = 0; p < 2; p++) begin
      int at = (p == 0) ? sync_at : extra_at;
      if (at >= 0) begin
        for (int k = 0; k < 24; k++) fb[at + k] = PAT[23 - k];
        for (int k = 24; k < 27; k++) if (at + k < FL) fb[at + k] = 1'b0;
      end
    end
    s_cnt = 0; s_first = -1; s_last = -1; a_hi = 0; l_rise = -1;
    prev_l = locked;
    for (int i = 0; i < FL; i++) begin
      step(fb[i]);
      if (frame_strobe) begin
        s_cnt++;
        if (s_first < 0) s_first = i;
        s_last = i;
      end
      if (sync_agree) a_hi++;
      if (locked && !prev_l && l_rise < 0) l_rise = i;
      prev_l = locked;
    end
    l_end = locked;
  endtask

  task automatic t_reset_idle();
    check("R1 strobe after reset", frame_strobe, 0);
    check("R1 locked after reset", locked, 0);
    check("R1 agree after reset", sync_agree, 0);
    send_frame(-1, -1);
    check("R1 no strobe without pattern", s_cnt, 0);
    send_frame(-1, -1);
    check("R1 no strobe second idle frame", s_cnt, 0);
  endtask

  task automatic t_acquire_lock();
    send_frame(0, -1);
    check("R3 acquisition strobe count", s_cnt, 1);
    check("R2 strobe right after last pattern bit", s_first, 23);
    check("R5 acquisition does not raise agree", a_hi, 0);
    check("R6 not locked after acquisition", l_end, 0);
    send_frame(0, -1);
    check("R4 first predicted slot", s_first, 23);
    check("R5 agree window start", a_hi, FL - 24);
    check("R6 not locked after one hit", l_end, 0);
    send_frame(0, -1);
    check("R6 lock rise cycle", l_rise, 24);
    check("R5 agree held whole frame", a_hi, FL);
    check("R10 single cycle strobe", s_cnt, 1);
  endtask

  task automatic t_dropout();
    send_frame(-1, -1);
    check("R4 interpolated strobe count", s_cnt, 1);
    check("R4 interpolated strobe position", s_first, 23);
    check("R5 agree lasts exactly one frame", a_hi, 24);
    check("R8 lock held over one dropout", l_end, 1);
    send_frame(0, -1);
    check("R5 agree reloaded", a_hi, FL - 24);
    check("R4 strobe after dropout", s_first, 23);
  endtask

  task automatic t_spurious();
    send_frame(0, 300);
    check("R7 spurious gives no strobe", s_cnt, 1);
    check("R7 spurious strobe position", s_last, 23);
    send_frame(0, -1);
    check("R7 timing unmoved", s_first, 23);
    check("R7 still locked", l_end, 1);
  endtask

  task automatic t_loss();
    for (int f = 1; f <= 7; f++) begin
      send_frame(-1, -1);
      check("R8 interpolated during loss run", s_first, 23);
      check("R8 lock held before eighth miss", l_end, 1);
    end
    send_frame(-1, -1);
    check("R8 eighth empty slot strobes", s_cnt, 1);
    check("R8 lock falls after eighth miss", l_end, 0);
    send_frame(-1, -1);
    check("R8 no strobe while hunting", s_cnt, 0);
  endtask

  task automatic t_reacquire();
    send_frame(100, -1);
    check("R3 new phase acquired", s_first, 123);
    send_frame(100, -1);
    check("R4 new phase predicted", s_first, 123);
    check("R6 unlocked after one hit", l_end, 0);
    send_frame(50, -1);
    check("R9 off-slot retime strobes", s_first, 73);
    check("R9 old slot abandoned", s_cnt, 1);
    send_frame(50, -1);
    check("R9 retimed slot hit", s_first, 73);
    check("R9 confirmation count restarted", l_end, 0);
    send_frame(50, -1);
    check("R6 lock after two hits at new timing", l_end, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_acquire_lock();
    t_dropout();
    t_spurious();
    t_loss();
    t_reacquire();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule